// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 64 pins, with 41 pins built by default. Software reaches it over a simple single-cycle register bus. Each feature uses one bit per pin. Pins are packed 32 to a 32-bit word, and each feature owns two consecutive words. The features are output enable, drive value, four interrupt enable banks, interrupt polarity and interrupt type. A write-one-to-clear status register records pin events.

Each pin input passes through a two-flop synchronizer. It is then qualified by its polarity bit and judged either as a level or as an edge. Every detected event is latched into the pin's status bit. A single registered interrupt line is the OR of the status bits masked by the first enable bank. The other three enable banks are storage only.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin n maps to bit (n mod 32) of the word at feature byte offset + (n / 32) * 4. The feature byte offsets are as follows. Status is at 0x48. Type is at 0x40. Polarity is at 0x38. Enable banks 0 to 3 are at 0x18, 0x20, 0x28 and 0x30. Drive is at 0x08. Output enable is at 0x00. Address bits [1:0] are ignored, and any unmapped word reads 0.
- R2: `pin_oe` mirrors the output-enable register. `pin_out[n]` equals the drive bit when `pin_oe[n]` is 1 and is 0 otherwise.
- R3: A read of the drive words returns the synchronized pin input, not the written drive value. A pin change becomes visible there after the second rising clock edge.
- R4: With type 0 (level) and polarity 0 (active high), a high pin sets its status bit. The bit sets again in every cycle the pin stays high, even directly after a clear.
- R5: With type 0 and polarity 1 (active low), a low pin sets its status bit in the same way.
- R6: With type 1 (edge) and polarity 0, a 0-to-1 transition sets the status bit. A 1-to-0 transition does not. The bit holds until it is cleared.
- R7: With type 1 and polarity 1, only a 1-to-0 transition sets the status bit. Changing the polarity while the pin is steady raises no event.
- R8: Writing a status word clears exactly the bits written as 1. Bits written as 0 keep their value. An event in the same cycle wins over the clear.
- R9: `irq` is the registered OR over all pins of (status AND enable bank 0). It changes one cycle after status or enable changes. Banks 1 to 3 never affect it.
- R10: All registers reset to 0. Bits at or above the implemented pin count read 0 and ignore writes.
- R11: A pin change reaches its status bit on the third rising edge after the change: two synchronizer stages, then the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of a 32-bit register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Pin input values, asynchronous |
| pin_out | output | NUM_PINS | Pin output values, gated by output enable |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The checker takes the status register to be changed only by detected events and by write-one-to-clear writes. The edge-hold and interrupt properties rest on that assumption. It also assumes that `rst_n` is low from time zero, so every past value it looks at is a reset value or a clocked one. The stimulus changes pins and bus signals only on falling clock edges. It holds every pin steady for at least three edges before judging status. It sets the type bits before the polarity bits, so that no configuration step passes through an unintended level-active state.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   // bit encodings of the type and polarity registers
   localparam logic TYPE_LEVEL = 1'b0;
   localparam logic TYPE_EDGE  = 1'b1;
   localparam logic POL_HIGH   = 1'b0;
   localparam logic POL_LOW    = 1'b1;

   // feature indices of the plain read/write registers
   localparam int F_OE   = 0;
   localparam int F_DRV  = 1;
   localparam int F_IEN0 = 2;
   localparam int F_IEN1 = 3;
   localparam int F_IEN2 = 4;
   localparam int F_IEN3 = 5;
   localparam int F_POL  = 6;
   localparam int F_TYP  = 7;
   localparam int NFEAT  = 8;

   // first 32-bit word index of the status register
   localparam int W_STAT = 18;

   // first 32-bit word index of each feature
   function automatic int feat_word(input int f);
      case (f)
         F_OE:    return 0;
         F_DRV:   return 2;
         F_IEN0:  return 6;
         F_IEN1:  return 8;
         F_IEN2:  return 10;
         F_IEN3:  return 12;
         F_POL:   return 14;
         default: return 16;
      endcase
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta   <= '0;
         q      <= '0;
         q_prev <= '0;
      end else begin
         meta   <= d;
         q      <= meta;
         q_prev <= q;
      end
   end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
   import gpio_bank_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] lvl_prev,
   input  logic [W-1:0] typ,
   input  logic [W-1:0] pol,
   output logic [W-1:0] evt
);
   for (genvar g = 0; g < W; g++) begin : g_pin
      logic act_now, act_old;
      assign act_now = lvl[g] ^ (pol[g] == POL_LOW);
      assign act_old = lvl_prev[g] ^ (pol[g] == POL_LOW);
      assign evt[g]  = (typ[g] == TYPE_EDGE) ? (act_now & ~act_old) : act_now;
   end
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
   parameter int                W    = 64,
   parameter logic [W-1:0]      IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] clr,
   input  logic [W-1:0] en,
   output logic [W-1:0] stat,
   output logic         irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         irq  <= 1'b0;
      end else begin
         stat <= ((stat & ~clr) | evt) & IMPL;
         irq  <= |(stat & en);
      end
   end
endmodule

// File: rtl/gpio_feat_reg.sv
module gpio_feat_reg #(
   parameter int           W      = 64,
   parameter int           IDX_W  = 6,
   parameter int           BASE   = 0,
   parameter logic [W-1:0] IMPL   = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] widx,
   input  logic [31:0]      wdata,
   output logic [W-1:0]     q
);
   localparam int NWORDS = W / 32;

   for (genvar k = 0; k < NWORDS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[k*32 +: 32] <= '0;
         else if (wr && widx == IDX_W'(BASE + k))
            q[k*32 +: 32] <= wdata & IMPL[k*32 +: 32];
      end
   end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 41,
   parameter int MAX_PINS = 64,
   parameter int ADDR_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);
   localparam int                NWORDS = MAX_PINS / 32;
   localparam int                IDX_W  = ADDR_W - 2;
   localparam logic [MAX_PINS-1:0] IMPL = {MAX_PINS{1'b1}} >> (MAX_PINS - NUM_PINS);

   if (MAX_PINS % 32 != 0 || MAX_PINS > 64 || MAX_PINS < 32) begin : g_bad_max
      $error("MAX_PINS must be 32 or 64");
   end
   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_num
      $error("NUM_PINS must lie in 1..MAX_PINS");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [IDX_W-1:0]    widx;
   logic [MAX_PINS-1:0] pin_ext, pad_q, pad_prev, evt, clr, stat_q;
   logic [MAX_PINS-1:0] feat_q [NFEAT];
   logic [MAX_PINS-1:0] oe_q, drv_q, ien0_q, typ_q, pol_q;

   assign widx = bus_addr[ADDR_W-1:2];

   always_comb begin
      pin_ext = '0;
      pin_ext[NUM_PINS-1:0] = pin_in;
   end

   for (genvar f = 0; f < NFEAT; f++) begin : g_feat
      gpio_feat_reg #(
         .W(MAX_PINS), .IDX_W(IDX_W), .BASE(feat_word(f)), .IMPL(IMPL)
      ) u_reg (
         .clk(clk), .rst_n(rst_n), .wr(bus_wr), .widx(widx),
         .wdata(bus_wdata), .q(feat_q[f])
      );
   end

   assign oe_q   = feat_q[F_OE];
   assign drv_q  = feat_q[F_DRV];
   assign ien0_q = feat_q[F_IEN0];
   assign typ_q  = feat_q[F_TYP];
   assign pol_q  = feat_q[F_POL];

   for (genvar k = 0; k < NWORDS; k++) begin : g_clr
      assign clr[k*32 +: 32] = (bus_wr && widx == IDX_W'(W_STAT + k)) ? bus_wdata : 32'd0;
   end

   gpio_sync #(.W(MAX_PINS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_ext), .q(pad_q), .q_prev(pad_prev)
   );

   gpio_evt_detect #(.W(MAX_PINS)) u_evt (
      .lvl(pad_q), .lvl_prev(pad_prev), .typ(typ_q), .pol(pol_q), .evt(evt)
   );

   gpio_status #(.W(MAX_PINS), .IMPL(IMPL)) u_stat (
      .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr), .en(ien0_q),
      .stat(stat_q), .irq(irq)
   );

   assign pin_oe  = oe_q[NUM_PINS-1:0];
   assign pin_out = drv_q[NUM_PINS-1:0] & oe_q[NUM_PINS-1:0];

   always_comb begin
      bus_rdata = '0;
      for (int f = 0; f < NFEAT; f++) begin
         for (int k = 0; k < NWORDS; k++) begin
            if (widx == IDX_W'(feat_word(f) + k))
               bus_rdata = (f == F_DRV) ? (pad_q[k*32 +: 32] & IMPL[k*32 +: 32])
                                        : feat_q[f][k*32 +: 32];
         end
      end
      for (int k = 0; k < NWORDS; k++) begin
         if (widx == IDX_W'(W_STAT + k))
            bus_rdata = stat_q[k*32 +: 32];
      end
   end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
   parameter int NUM_PINS = 41,
   parameter int MAX_PINS = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq,
   input logic [MAX_PINS-1:0] stat,
   input logic [MAX_PINS-1:0] typ,
   input logic [MAX_PINS-1:0] ien0,
   input logic [MAX_PINS-1:0] clr
);
   localparam logic [MAX_PINS-1:0] IMPL = {MAX_PINS{1'b1}} >> (MAX_PINS - NUM_PINS);

   assert_oe_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   assert_impl_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat & ~IMPL) == '0);

   assert_edge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat & typ & ~clr) & ~stat) == '0);

   assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat & ien0) == '0) |-> !irq);

   assert_irq_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat & ien0) != '0) |-> irq);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
   .NUM_PINS(NUM_PINS), .MAX_PINS(MAX_PINS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
   .stat(stat_q), .typ(typ_q), .ien0(ien0_q), .clr(clr)
);

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/100ps
module gpio_bank_ctrl_bench;
   localparam int NP = 41;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic          irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   typedef struct {
      int          kind;   // 0 read data, 1 irq, 2 pin_out, 3 pin_oe
      logic [63:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];
   event  sample_ev;

   always #10 clk = ~clk;

   gpio_bank_ctrl u_gpio_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(sample_ev);
         #0.5;
         while (sb_q.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = sb_q.pop_front();
            case (it.kind)
               0:       act = {32'd0, bus_rdata};
               1:       act = {63'd0, irq};
               2:       act = {23'd0, pin_out};
               default: act = {23'd0, pin_oe};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic push(input int kind, input logic [63:0] exp, input string tag);
      item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      -> sample_ev;
      #1;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      push(0, {32'd0, exp}, tag);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      neg(3);
      rst_n = 1'b1;
      neg(1);
      // reset state
      rd(8'h00, 32'h0, "R10 oe reset");
      rd(8'h48, 32'h0, "R10 status reset");
      push(1, 64'd0, "R10 irq reset");
      push(3, 64'd0, "R10 pin_oe reset");

      // output enable and drive, banked words
      wr(8'h00, 32'hFFFF_0000);
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h08, 32'hFF00_FF00);
      wr(8'h0C, 32'h0000_00AA);
      push(3, 64'h1FF_FFFF_0000, "R2 R1 pin_oe");
      push(2, 64'h0AA_FF00_0000, "R2 pin_out gated");
      rd(8'h04, 32'h1FF, "R10 upper bits ignored");
      rd(8'h10, 32'h0, "R1 unmapped word");

      // level high on pin 5, readback and latency
      pin_in[5] = 1'b1;
      neg(1);
      rd(8'h08, 32'h0, "R3 readback after one edge");
      rd(8'h48, 32'h0, "R11 status after one edge");
      neg(1);
      rd(8'h08, 32'h20, "R3 readback after two edges");
      rd(8'h48, 32'h0, "R11 status after two edges");
      neg(1);
      rd(8'h48, 32'h20, "R4 R11 level high sets");
      wr(8'h48, 32'h20);
      rd(8'h48, 32'h20, "R4 level re-asserts after clear");
      pin_in[5] = 1'b0;
      neg(3);
      wr(8'h48, 32'h20);
      rd(8'h48, 32'h0, "R4 cleared once inactive");

      // interrupt gating
      wr(8'h20, 32'h20);
      pin_in[5] = 1'b1;
      neg(3);
      rd(8'h48, 32'h20, "R4 level set again");
      push(1, 64'd0, "R9 bank 1 does not gate");
      rd(8'h20, 32'h20, "R1 bank 1 readback");
      wr(8'h18, 32'h20);
      push(1, 64'd0, "R9 irq one cycle late");
      neg(1);
      push(1, 64'd1, "R9 irq asserted");

      // rising edge on pin 40
      wr(8'h44, 32'h100);
      pin_in[40] = 1'b1;
      neg(2);
      rd(8'h4C, 32'h0, "R11 edge after two edges");
      neg(1);
      rd(8'h4C, 32'h100, "R6 rising edge sets");
      pin_in[40] = 1'b0;
      neg(4);
      rd(8'h4C, 32'h100, "R6 edge status holds");
      wr(8'h4C, 32'h0);
      rd(8'h4C, 32'h100, "R8 write zero no effect");
      wr(8'h4C, 32'h100);
      rd(8'h4C, 32'h0, "R8 write one clears");
      neg(3);
      rd(8'h4C, 32'h0, "R6 falling ignored");

      // falling edge on pin 33
      wr(8'h44, 32'h102);
      wr(8'h3C, 32'h002);
      neg(3);
      rd(8'h4C, 32'h0, "R7 polarity change no event");
      pin_in[33] = 1'b1;
      neg(4);
      rd(8'h4C, 32'h0, "R7 rising ignored");
      rd(8'h0C, 32'h2, "R3 R1 readback upper word");
      pin_in[33] = 1'b0;
      neg(3);
      rd(8'h4C, 32'h2, "R7 falling edge sets");
      pin_in[40] = 1'b1;
      neg(3);
      rd(8'h4C, 32'h102, "R6 second rising edge");
      wr(8'h4C, 32'h100);
      rd(8'h4C, 32'h2, "R8 per-bit clear");

      // level low on pin 2
      wr(8'h38, 32'h4);
      neg(1);
      rd(8'h48, 32'h24, "R5 level low sets");
      wr(8'h48, 32'h4);
      rd(8'h48, 32'h24, "R5 level low re-asserts");
      pin_in[2] = 1'b1;
      neg(3);
      wr(8'h48, 32'h4);
      rd(8'h48, 32'h20, "R5 cleared once high");

      // disable interrupt and outputs
      wr(8'h18, 32'h0);
      neg(1);
      push(1, 64'd0, "R9 irq drops");
      wr(8'h00, 32'h0);
      push(2, 64'h0AA_0000_0000, "R2 pin_out low word off");

      neg(2);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule